// File: doc/BRIEF.md
# Start-Bit-Triggered Triple-Oversampling Serial Receiver

This block receives asynchronous serial frames (one start bit, 5 to 8 data bits sent least significant bit first, one stop bit, no parity). A programmable divider produces a sample tick at three times the baud rate. While armed, the receiver polls the synchronised line on every tick. The first low sample is taken as an active-low frame marker. From then on the line is no longer watched for a new start, and a fixed number of samples is shifted into a capture register. The data word is rebuilt by keeping the middle sample of each three-sample group. No majority vote and no centre search is used.

The recovered word leaves on a valid/ready stream port. `rx_valid` doubles as the receive-full flag. While it is high, `rx_word` and `rx_frame_err` hold steady until the consumer raises `rx_ready`; the word transfers on a clock edge where both are high. Back-pressure is not queued. A frame that completes while a word is still held (including the cycle in which that word is accepted) is discarded, and the held word is kept. After each frame the receiver waits for a high sample before it arms again, so a line stuck low yields one frame and then silence.

Top module: `os3_uart_rx`

## Requirements
- R1: The sample tick repeats every 2 × (`div_reload` + 1) clock cycles, so `div_reload` = f_clk / (6 × baud) − 1 gives three samples per bit; frames sent at that bit period (6 × (`div_reload` + 1) clocks) are decoded for more than one divider value.
- R2: When armed and idle, the first tick that samples the synchronised line low starts a capture.
- R3: During a capture, low levels on the line never restart the frame; a data word of all zeros is decoded as 0x00.
- R4: The width W is `word_bits` clamped to the range 5..8 (values below 5 act as 5, above 8 as 8). A capture takes N = 3 × (W + 1) samples after the start sample. With the first sample at the top of the capture register, data bit k is taken from capture position 3 × (W − k) − 1 (position 23 − 3k for W = 8).
- R5: `rx_word` carries bit 0 as the first received data bit, and bits W and above are zero.
- R6: One further tick after the capture samples the middle of the stop bit; `rx_frame_err` is 1 exactly when that sample is 0, and it is delivered with the word.
- R7: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid`, `rx_word` and `rx_frame_err` stay unchanged.
- R8: A frame that completes while `rx_valid` is 1 is dropped; the held word is delivered unchanged and no extra word follows.
- R9: After each frame the receiver starts no capture until a tick samples the line high; a line held low yields exactly one frame (word 0, `rx_frame_err` 1).
- R10: After reset, `rx_valid` is 0 and the receiver waits for a high line before arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| div_reload | input | DIV_W (16) | Half-period reload of the sample divider |
| word_bits | input | 4 | Requested data width, clamped to 5..8 |
| rx_word | output | MAX_BITS (8) | Recovered data word |
| rx_frame_err | output | 1 | Stop-bit middle sample was low |
| rx_valid | output | 1 | Word held for transfer; receive-full flag |
| rx_ready | input | 1 | Consumer accepts the held word |

## Verification
A wrong capture count or a wrong group alignment shows as shifted or corrupted bits in `rx_word` on the very next frame. The same is true of a wrong clamp. A divider off by one drifts the sampling point until the upper data bits or the stop sample land in the wrong bit cell, so it appears within one frame at the test divider settings. A faulty re-arm rule shows only with a held-low line, as extra zero words with `rx_frame_err` set. A broken holding slot shows during a stall, where the held word changes or a second word appears after release.

// File: rtl/os3_pkg.sv
package os3_pkg;

  localparam int WSEL_W = 4;

  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_IDLE = 2'd1,
    ST_CAP  = 2'd2,
    ST_STOP = 2'd3
  } cap_state_e;

  function automatic logic [WSEL_W-1:0] clamp_width(input logic [WSEL_W-1:0] req,
                                                    input int lo, input int hi);
    if (int'(req) < lo)      return WSEL_W'(lo);
    else if (int'(req) > hi) return WSEL_W'(hi);
    else                     return req;
  endfunction

endpackage

// File: rtl/os3_sync.sv
module os3_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/os3_tick.sv
module os3_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] half_cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap = (half_cnt_q >= reload);
  assign tick = wrap & phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt_q <= '0;
      phase_q    <= 1'b0;
    end else if (wrap) begin
      half_cnt_q <= '0;
      phase_q    <= ~phase_q;
    end else begin
      half_cnt_q <= half_cnt_q + 1'b1;
    end
  end

  // Ticks can never fall on adjacent cycles: each one needs two wraps.
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/os3_capture.sv
module os3_capture
  import os3_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             line,
  input  logic [WSEL_W-1:0]                word_bits,
  output logic [3*(MAX_BITS+1)-1:0]        cap,
  output logic [WSEL_W-1:0]                wsel,
  output logic                             done,
  output logic                             stop_ok
);
  localparam int NMAX = 3 * (MAX_BITS + 1);
  localparam int CW   = $clog2(NMAX + 1);

  cap_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     n_last;
  logic [NMAX-1:0]   shreg_q;
  logic [WSEL_W-1:0] wlat_q;
  logic              done_q, stop_q;
  logic              last_sample;

  assign n_last      = CW'((3 * (int'(wlat_q) + 1)) - 1);
  assign last_sample = tick && (cnt_q == n_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ARM;
      cnt_q   <= '0;
      shreg_q <= '0;
      wlat_q  <= WSEL_W'(MAX_BITS);
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_ARM: if (tick && line) st_q <= ST_IDLE;
        ST_IDLE: if (tick && !line) begin
          st_q    <= ST_CAP;
          cnt_q   <= '0;
          shreg_q <= '0;
          wlat_q  <= clamp_width(word_bits, MIN_BITS, MAX_BITS);
        end
        ST_CAP: if (tick) begin
          shreg_q <= {shreg_q[NMAX-2:0], line};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == n_last) st_q <= ST_STOP;
        end
        ST_STOP: if (tick) begin
          stop_q <= line;
          done_q <= 1'b1;
          st_q   <= ST_ARM;
        end
        default: st_q <= ST_ARM;
      endcase
    end
  end

  assign cap     = shreg_q;
  assign wsel    = wlat_q;
  assign done    = done_q;
  assign stop_ok = stop_q;

  p_sync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && tick && !line) |=> (st_q == ST_CAP));
  p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAP && !last_sample) |=> (st_q == ST_CAP));
  p_cap_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAP && last_sample) |=> (st_q == ST_STOP));
  p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(st_q) == ST_STOP));
  p_arm_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM && !(tick && line)) |=> (st_q == ST_ARM));
endmodule

// File: rtl/os3_pick.sv
module os3_pick
  import os3_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8
) (
  input  logic [3*(MAX_BITS+1)-1:0] cap,
  input  logic [WSEL_W-1:0]         wsel,
  output logic [MAX_BITS-1:0]       word
);
  // Middle sample of each group; positions depend on the latched width.
  always_comb begin
    word = '0;
    for (int w = MIN_BITS; w <= MAX_BITS; w++) begin
      if (int'(wsel) == w) begin
        for (int k = 0; k < w; k++) word[k] = cap[3*(w-k)-1];
      end
    end
  end
endmodule

// File: rtl/os3_uart_rx.sv
module os3_uart_rx
  import os3_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 8,
  parameter int SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxd_in,
  input  logic [DIV_W-1:0]    div_reload,
  input  logic [WSEL_W-1:0]   word_bits,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                rx_frame_err,
  output logic                rx_valid,
  input  logic                rx_ready
);
  localparam int NMAX = 3 * (MAX_BITS + 1);

  logic                line_s, tick;
  logic [NMAX-1:0]     cap;
  logic [WSEL_W-1:0]   wsel;
  logic                done, stop_ok;
  logic [MAX_BITS-1:0] picked;
  logic [MAX_BITS-1:0] word_q;
  logic                err_q, valid_q;

  os3_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rxd_in), .sync_out(line_s));

  os3_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .reload(div_reload), .tick(tick));

  os3_capture #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .word_bits(word_bits), .cap(cap), .wsel(wsel),
    .done(done), .stop_ok(stop_ok));

  os3_pick #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_pick (
    .cap(cap), .wsel(wsel), .word(picked));

  // Single holding slot: a completing frame is kept only if the slot is empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (valid_q && rx_ready) valid_q <= 1'b0;
      if (done && !valid_q) begin
        valid_q <= 1'b1;
        word_q  <= picked;
        err_q   <= ~stop_ok;
      end
    end
  end

  assign rx_word      = word_q;
  assign rx_frame_err = err_q;
  assign rx_valid     = valid_q;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rx_ready) |=> (valid_q && $stable(word_q) && $stable(err_q)));
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid_q) |=> ($stable(word_q) && $stable(err_q)));
  p_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !done) |=> !valid_q);
endmodule

// File: tb/test_os3_uart_rx.sv
module test_os3_uart_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] reload = 16'd1;
  logic [3:0]  wbits = 4'd8;
  logic        ready = 1'b1;
  logic [7:0]  word;
  logic        ferr, valid;

  int checks = 0, errors = 0, bitclk = 12;
  logic [7:0] exp_w[$];
  logic       exp_e[$];
  string      exp_t[$];

  always #10 clk = ~clk;

  os3_uart_rx i_os3_uart_rx (
    .clk(clk), .rst_n(rst_n), .rxd_in(rxd), .div_reload(reload),
    .word_bits(wbits), .rx_word(word), .rx_frame_err(ferr),
    .rx_valid(valid), .rx_ready(ready));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic line_for(input logic v, input int n);
    rxd = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] d, input int w, input logic stop_lvl,
                      input bit expect_it, input string tag);
    if (expect_it) begin
      exp_w.push_back(d & 8'((1 << w) - 1));
      exp_e.push_back(!stop_lvl);
      exp_t.push_back(tag);
    end
    line_for(1'b0, bitclk);
    for (int k = 0; k < w; k++) line_for(d[k], bitclk);
    line_for(stop_lvl, bitclk);
    line_for(1'b1, 2 * bitclk);
  endtask

  // Monitor: pops the scoreboard on every transfer
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      if (exp_w.size() == 0) begin
        check(0, "R8 unexpected extra word", word, 0);
      end else begin
        logic [7:0] ew;
        logic ee;
        string et;
        ew = exp_w.pop_front();
        ee = exp_e.pop_front();
        et = exp_t.pop_front();
        check(word == ew, {et, " word R5"}, word, ew);
        check(ferr == ee, {et, " frame flag R6"}, ferr, ee);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R10 reset valid", valid, 0);
    line_for(1'b1, 40);

    // R1/R2/R5 several patterns at 8 bits, divider 1
    send(8'hA5, 8, 1'b1, 1, "R2 a5");
    send(8'h96, 8, 1'b1, 1, "R5 96");
    send(8'h00, 8, 1'b1, 1, "R3 zeros");
    send(8'hFF, 8, 1'b1, 1, "R5 ff");
    line_for(1'b1, 7);               // shift phase against the tick
    send(8'h3C, 8, 1'b1, 1, "R2 phase");

    // R4 other widths and clamping
    wbits = 4'd5; send(8'h15, 5, 1'b1, 1, "R4 w5");
    wbits = 4'd6; send(8'h2B, 6, 1'b1, 1, "R4 w6");
    wbits = 4'd7; send(8'h51, 7, 1'b1, 1, "R4 w7");
    wbits = 4'd2; send(8'h0A, 5, 1'b1, 1, "R4 clamp low");
    wbits = 4'd15; send(8'hC3, 8, 1'b1, 1, "R4 clamp high");
    wbits = 4'd8;

    // R6 framing error
    send(8'h5A, 8, 1'b0, 1, "R6 bad stop");

    // R1 other divider
    reload = 16'd3; bitclk = 24;
    line_for(1'b1, 3 * bitclk);
    send(8'h69, 8, 1'b1, 1, "R1 div3");
    send(8'h81, 8, 1'b1, 1, "R1 div3b");

    // R7/R8 back-pressure
    ready = 1'b0;
    send(8'h4E, 8, 1'b1, 1, "R7 held");
    @(negedge clk);
    check(valid && word == 8'h4E, "R7 held word", word, 8'h4E);
    send(8'hB1, 8, 1'b1, 0, "");
    @(negedge clk);
    check(valid && word == 8'h4E && !ferr, "R8 dropped frame kept held word", word, 8'h4E);
    @(posedge clk); #1 ready = 1'b1;
    line_for(1'b1, 3 * bitclk);

    // R9 line held low: one frame then silence
    exp_w.push_back(8'h00); exp_e.push_back(1'b1); exp_t.push_back("R9 held low");
    line_for(1'b0, 30 * bitclk);
    line_for(1'b1, 4 * bitclk);
    send(8'h7E, 8, 1'b1, 1, "R9 recover");

    for (int i = 0; i < 2000 && exp_w.size() != 0; i++) @(posedge clk);
    @(negedge clk);
    check(exp_w.size() == 0, "R9 all words delivered", exp_w.size(), 0);
    check(valid == 1'b0, "R8 no extra word pending", valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule